// File: doc/BRIEF.md
# Exception Restart Address Capture

This block holds the address at which execution resumes once an exception has been handled. When an exception is reported, the block stores the virtual address of the faulting instruction. If that instruction sits in a branch or jump delay slot, or if it is a 16-bit instruction that follows an extend prefix, the block stores the address of the preceding instruction instead, and it raises the branch-delay flag. As a result, the stored value never points at a delay-slot instruction.

A strap input selects whether the compressed 16-bit instruction set is enabled. The block samples the strap on the first clock after reset is released. When the compressed set is enabled, bit 0 of the stored value records the instruction-set mode that was active at the exception. The upper bits hold the address.

While the status EXL bit is set, exceptions leave both the register and the flag untouched. Software can write the register at any time. A software write loses only to an exception that is not blocked by EXL.

Top module: `exc_restart_capture`

## Requirements
- R1: While `rst` is high, and on the first clock after it is released, `epc` reads 0 and `bd` reads 0.
- R2: An exception with `exl` low, not in a delay slot and not eligible for the extend rule, loads the upper bits `epc[W-1:1]` from `exc_pc` and clears `bd` on that clock edge.
- R3: An exception with `exl` low and `in_delay` high loads `epc[W-1:1]` from `prev_pc` and sets `bd` to 1.
- R4: When the compressed set is enabled, a captured `epc[0]` equals `isa16` (1 = 16-bit mode), and `epc[W-1:1]` comes from the selected address.
- R5: When the compressed set is enabled and `isa16` is 1, an exception with `after_ext` high loads the address from `prev_pc` and sets `bd`. When `isa16` is 0 or the set is disabled, `after_ext` has no effect.
- R6: While `exl` is 1, an exception changes neither `epc` nor `bd`.
- R7: A software write (`sw_we`) loads `epc` with the full `sw_wdata` on the clock edge and leaves `bd` unchanged.
- R8: When a software write and an exception that `exl` does not block happen in the same cycle, the exception wins. When `exl` is 1, the software write takes effect.
- R9: The compressed-set enable is latched from `cmp_strap` on the first clock after `rst` falls. Later changes of `cmp_strap` are ignored until the next reset.
- R10: When the compressed set is disabled, `isa16` is ignored, and `epc[0]` is bit 0 of the selected address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (real-time-clock reset domain) |
| cmp_strap | input | 1 | Compressed-instruction-set enable strap |
| exc_valid | input | 1 | An exception is taken this cycle |
| exc_pc | input | W | Virtual address of the faulting instruction |
| prev_pc | input | W | Virtual address of the preceding branch/jump or extend instruction |
| in_delay | input | 1 | The faulting instruction sits in a delay slot |
| after_ext | input | 1 | The faulting 16-bit instruction follows an extend prefix |
| isa16 | input | 1 | Current mode is the 16-bit instruction set |
| exl | input | 1 | Status EXL bit |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | W | Software write data |
| epc | output | W | Restart address register |
| bd | output | 1 | Branch-delay flag |

## Verification
Two cases are hard to reach from the ports. The first is the strap latch: the enable is sampled only once after reset, so the bench has to toggle `cmp_strap` freely after that first clock and then show that the tagging of `epc[0]` still follows the value present at release. The bench runs two phases, each started by its own reset with a different strap value, and flips the strap pin at random inside each phase.

The second is the overlap of EXL, an exception and a software write in one cycle. Random stimulus sets each of these inputs often enough that all combinations of the three appear many times. Directed cycles force the extend-prefix case in both instruction-set modes.

// File: rtl/erc_pkg.sv
package erc_pkg;

    // Control decided for one exception capture
    typedef struct packed {
        logic take;      // capture allowed (exception and not EXL)
        logic use_prev;  // select preceding instruction address
        logic tag_en;    // compressed set enabled: bit 0 carries mode
        logic mode;      // mode tag written into bit 0
    } capt_ctl_t;

    // Decide whether the preceding instruction address is the restart point
    function automatic logic pick_prev(input logic delay_slot,
                                       input logic follows_ext,
                                       input logic mode16,
                                       input logic cmp_on);
        return delay_slot | (follows_ext & mode16 & cmp_on);
    endfunction

endpackage

// File: rtl/erc_strap_latch.sv
module erc_strap_latch (
    input  logic clk,
    input  logic rst,
    input  logic strap_pin,
    output logic cmp_on
);
    logic armed_q;
    logic strap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b1;
            strap_q <= 1'b0;
        end else if (armed_q) begin
            armed_q <= 1'b0;
            strap_q <= strap_pin;
        end
    end

    // In the sampling cycle itself the pin value is already in force
    assign cmp_on = armed_q ? strap_pin : strap_q;
endmodule

// File: rtl/erc_select.sv
module erc_select
    import erc_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         exc_valid,
    input  logic         exl,
    input  logic [W-1:0] exc_pc,
    input  logic [W-1:0] prev_pc,
    input  logic         in_delay,
    input  logic         after_ext,
    input  logic         isa16,
    input  logic         cmp_on,
    output capt_ctl_t    ctl,
    output logic [W-1:0] cap_val
);
    logic [W-1:0] base;

    always_comb begin
        ctl.take     = exc_valid & ~exl;
        ctl.use_prev = pick_prev(in_delay, after_ext, isa16, cmp_on);
        ctl.tag_en   = cmp_on;
        ctl.mode     = isa16 & cmp_on;
        base         = ctl.use_prev ? prev_pc : exc_pc;
        cap_val      = base;
        if (ctl.tag_en) begin
            cap_val[0] = ctl.mode;
        end
    end
endmodule

// File: rtl/erc_reg.sv
module erc_reg
    import erc_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  capt_ctl_t    ctl,
    input  logic [W-1:0] cap_val,
    input  logic         sw_we,
    input  logic [W-1:0] sw_wdata,
    output logic [W-1:0] epc,
    output logic         bd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            epc <= '0;
            bd  <= 1'b0;
        end else if (ctl.take) begin
            epc <= cap_val;
            bd  <= ctl.use_prev;
        end else if (sw_we) begin
            epc <= sw_wdata;
        end
    end
endmodule

// File: rtl/exc_restart_capture.sv
module exc_restart_capture
    import erc_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cmp_strap,
    input  logic         exc_valid,
    input  logic [W-1:0] exc_pc,
    input  logic [W-1:0] prev_pc,
    input  logic         in_delay,
    input  logic         after_ext,
    input  logic         isa16,
    input  logic         exl,
    input  logic         sw_we,
    input  logic [W-1:0] sw_wdata,
    output logic [W-1:0] epc,
    output logic         bd
);
    logic         cmp_on;
    capt_ctl_t    ctl;
    logic [W-1:0] cap_val;

    erc_strap_latch u_strap (
        .clk       (clk),
        .rst       (rst),
        .strap_pin (cmp_strap),
        .cmp_on    (cmp_on)
    );

    erc_select #(.W(W)) u_sel (
        .exc_valid (exc_valid),
        .exl       (exl),
        .exc_pc    (exc_pc),
        .prev_pc   (prev_pc),
        .in_delay  (in_delay),
        .after_ext (after_ext),
        .isa16     (isa16),
        .cmp_on    (cmp_on),
        .ctl       (ctl),
        .cap_val   (cap_val)
    );

    erc_reg #(.W(W)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .cap_val  (cap_val),
        .sw_we    (sw_we),
        .sw_wdata (sw_wdata),
        .epc      (epc),
        .bd       (bd)
    );
endmodule

// File: rtl/exc_restart_capture_chk.sv
module exc_restart_capture_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst,
    input logic         exc_valid,
    input logic [W-1:0] exc_pc,
    input logic [W-1:0] prev_pc,
    input logic         in_delay,
    input logic         exl,
    input logic         sw_we,
    input logic [W-1:0] sw_wdata,
    input logic [W-1:0] epc,
    input logic         bd
);
    // R1: reset clears the outputs
    a_r1_reset_clear: assert property (@(posedge clk) rst |=> (epc == '0 && bd == 1'b0));

    // R3: delay-slot capture takes the preceding address and sets BD
    a_r3_delay_prev: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && !exl && in_delay) |=> (bd && epc[W-1:1] == $past(prev_pc[W-1:1])));

    // R6: EXL blocks capture when no software write competes
    a_r6_exl_freeze: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && exl && !sw_we) |=> ($stable(epc) && $stable(bd)));

    // R7: software write loads the full word and leaves BD alone
    a_r7_sw_write: assert property (@(posedge clk) disable iff (rst)
        (sw_we && !(exc_valid && !exl)) |=> (epc == $past(sw_wdata) && $stable(bd)));

    // R8: capture wins over a simultaneous software write
    a_r8_capture_wins: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && !exl && sw_we && in_delay) |=> (epc[W-1:1] == $past(prev_pc[W-1:1])));
endmodule

bind exc_restart_capture exc_restart_capture_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .exc_valid (exc_valid),
    .exc_pc    (exc_pc),
    .prev_pc   (prev_pc),
    .in_delay  (in_delay),
    .exl       (exl),
    .sw_we     (sw_we),
    .sw_wdata  (sw_wdata),
    .epc       (epc),
    .bd        (bd)
);

// File: tb/exc_restart_capture_tb.sv
module exc_restart_capture_tb;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst;
    logic         cmp_strap;
    logic         exc_valid;
    logic [W-1:0] exc_pc;
    logic [W-1:0] prev_pc;
    logic         in_delay;
    logic         after_ext;
    logic         isa16;
    logic         exl;
    logic         sw_we;
    logic [W-1:0] sw_wdata;
    logic [W-1:0] epc;
    logic         bd;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] m_epc;
    logic         m_bd;
    logic         m_en;

    always #5 clk = ~clk;

    exc_restart_capture #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .cmp_strap(cmp_strap), .exc_valid(exc_valid),
        .exc_pc(exc_pc), .prev_pc(prev_pc), .in_delay(in_delay),
        .after_ext(after_ext), .isa16(isa16), .exl(exl), .sw_we(sw_we),
        .sw_wdata(sw_wdata), .epc(epc), .bd(bd)
    );

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input logic [W-1:0] act_v, input logic act_b,
                       input logic [W-1:0] exp_v, input logic exp_b);
        checks++;
        if (act_v !== exp_v || act_b !== exp_b) begin
            errors++;
            $display("FAIL %s: actual epc=%h bd=%b expected epc=%h bd=%b",
                     req, act_v, act_b, exp_v, exp_b);
        end
    endtask

    function automatic string req_tag();
        if (exc_valid && exl) return sw_we ? "R8" : "R6";
        if (exc_valid) begin
            if (sw_we) return "R8";
            if (in_delay) return "R3";
            if (after_ext && isa16 && m_en) return "R5";
            if (after_ext) return "R5";
            if (!m_en) return "R10";
            return m_en ? "R4" : "R2";
        end
        if (sw_we) return "R7";
        return "R9";
    endfunction

    // Reference model: one clock edge of the requirements
    task automatic model_step();
        logic         use_prev;
        logic [W-1:0] v;
        if (exc_valid && !exl) begin
            use_prev = in_delay | (after_ext & isa16 & m_en);
            v = use_prev ? prev_pc : exc_pc;
            if (m_en) v[0] = isa16;
            m_epc = v;
            m_bd  = use_prev;
        end else if (sw_we) begin
            m_epc = sw_wdata;
        end
    endtask

    task automatic idle_inputs();
        exc_valid = 0; in_delay = 0; after_ext = 0; isa16 = 0; exl = 0;
        sw_we = 0; exc_pc = '0; prev_pc = '0; sw_wdata = '0;
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst = 1; cmp_strap = strap; idle_inputs();
        @(negedge clk);
        chk("R1", epc, bd, '0, 1'b0);
        @(negedge clk);
        rst = 0;
        m_epc = '0; m_bd = 0; m_en = strap;
        @(negedge clk);
        chk("R1", epc, bd, '0, 1'b0);
    endtask

    task automatic one_cycle(input string req);
        model_step();
        @(negedge clk);
        chk(req, epc, bd, m_epc, m_bd);
    endtask

    task automatic directed();
        // plain fault, 16-bit mode, extend eligible or not per enable
        idle_inputs(); exc_valid = 1; isa16 = 1; after_ext = 1;
        exc_pc = 64'h0000_1234_5678_9ab0; prev_pc = 64'h0000_1234_5678_9aac;
        one_cycle("R5");
        idle_inputs(); exc_valid = 1; isa16 = 0; after_ext = 1;
        exc_pc = 64'hffff_0000_0000_1001; prev_pc = 64'h0000_0000_0000_0ffd;
        one_cycle("R5");
        idle_inputs(); exc_valid = 1; in_delay = 1;
        exc_pc = 64'h10; prev_pc = 64'hc;
        one_cycle("R3");
        idle_inputs(); exc_valid = 1; exc_pc = 64'h2001; prev_pc = 64'h1fff; isa16 = 1;
        one_cycle(m_en ? "R4" : "R10");
        idle_inputs(); exc_valid = 1; exl = 1; exc_pc = 64'hdead; sw_we = 1; sw_wdata = 64'hbeef_0001;
        one_cycle("R8");
        idle_inputs(); exc_valid = 1; exl = 1; exc_pc = 64'h5555;
        one_cycle("R6");
        idle_inputs(); exc_valid = 1; in_delay = 1; sw_we = 1; sw_wdata = 64'h77;
        exc_pc = 64'h40; prev_pc = 64'h3c;
        one_cycle("R8");
        idle_inputs(); sw_we = 1; sw_wdata = 64'h0123_4567_89ab_cdef;
        one_cycle("R7");
    endtask

    task automatic random_run(input int n);
        for (int i = 0; i < n; i++) begin
            exc_valid = ($urandom % 3) != 0;
            in_delay  = ($urandom % 4) == 0;
            after_ext = ($urandom % 3) == 0;
            isa16     = $urandom % 2;
            exl       = ($urandom % 4) == 0;
            sw_we     = ($urandom % 4) == 0;
            exc_pc    = {$urandom, $urandom};
            prev_pc   = {$urandom, $urandom};
            sw_wdata  = {$urandom, $urandom};
            cmp_strap = $urandom % 2; // R9: must be ignored after sampling
            one_cycle(req_tag());
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst = 1; cmp_strap = 0; idle_inputs();
        do_reset(1'b1);
        directed();
        random_run(1500);
        do_reset(1'b0);
        directed();
        random_run(1500);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule